// File: doc/BRIEF.md
# Programmable Pixel-Clock Edge Generator

This block produces the horizontal transfer clocks for an image sensor, the reset gate clock and two internal sample strobes (one for the reset level and one for the signal level). A fine phase counter splits every pixel period into a fixed number of steps, 48 by default: a 40 MHz pixel clock with a step of roughly 500 ps. Each output is placed on that grid by location values read from a register file.

The main horizontal clock has programmable rising and falling locations and a polarity bit. Its companions are derived from it: the third clock follows the first, and the second and fourth are the complements of the first and third. The reset gate clock has its own pair of locations and its own polarity bit. Each strobe is a pulse one step wide, at its own programmed location.

A horizontal blanking input holds the horizontal clocks at a fixed level. A register bit chooses whether that input is used directly or retimed through one register stage. An active-low timing-core reset bit forces every output to its inactive level and restarts the phase grid.

Top module: `pcg_edge_gen`

## Requirements
- R1: When rise < fall, the pre-polarity level of the main H clock is 1 for the phase steps rise to fall-1 and 0 otherwise. An output reflects the phase step of the previous clock, and the first clock after the phase grid starts is step 0.
- R2: When rise > fall, the window wraps: the pre-polarity level is 1 for steps >= rise or < fall.
- R3: When rise == fall, the output stays at its inactive level, which is its polarity bit.
- R4: Any location value of STEPS (48) or above is treated as STEPS-1 (47).
- R5: The output is (window AND NOT blanked) XOR polarity. With polarity 1 the H clocks are inverted and idle high.
- R6: h_comp_o[i] is always the complement of h_main_o[i]. Bit 0 of each bus is H1 or H2 and bit 1 is H3 or H4. H3 follows H1.
- R7: The reset gate clock uses its own rise and fall locations and its own polarity bit, following the R1 to R4 window rules.
- R8: shp_o and shd_o are each high for exactly one step, the step after the phase equals the clamped location.
- R9: While blanking is in effect, the H clocks sit at their inactive level. The reset gate clock and the strobes are not affected.
- R10: With hblk_retime = 0, blanking takes effect on the output one clock after hblk_i is sampled. With hblk_retime = 1 it takes effect one clock later.
- R11: While core_rst_n is low, every output is inactive: H at h_pol, the complements at NOT h_pol, RG at rg_pol and the strobes at 0. After release the phase grid restarts at step 0.
- R12: While rst_n is low, the outputs take the same inactive levels as in R11 and the blanking retime register clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fine step clock (STEPS per pixel) |
| rst_n | input | 1 | Synchronous active-low reset |
| core_rst_n | input | 1 | Register bit: active-low timing-core reset |
| h_pol | input | 1 | Polarity for the H clocks |
| h_rise | input | LOC_W | H1 rising location |
| h_fall | input | LOC_W | H1 falling location |
| rg_pol | input | 1 | Reset gate polarity |
| rg_rise | input | LOC_W | Reset gate rising location |
| rg_fall | input | LOC_W | Reset gate falling location |
| shp_loc | input | LOC_W | Reset-level strobe location |
| shd_loc | input | LOC_W | Signal-level strobe location |
| hblk_i | input | 1 | Horizontal blanking request |
| hblk_retime | input | 1 | 1 selects the registered blanking input |
| h_main_o | output | H_PAIRS | H1, H3 |
| h_comp_o | output | H_PAIRS | H2, H4 |
| rg_o | output | 1 | Reset gate clock |
| shp_o | output | 1 | Reset-level sample strobe |
| shd_o | output | 1 | Signal-level sample strobe |

## Verification
Every output is one register past the phase step, so each level is due on the clock after the step that produces it. Blanking is due one clock after hblk_i is sampled when the input is used directly, and two clocks after when it is retimed. After a core reset is released, the first output edge reflects step 0. The reference model advances its own phase integer on each rising edge, using the input values present at that edge. The bench drives inputs and compares outputs only on falling edges, so every comparison sees the value due for the step just registered.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
   // Clamp a programmed location onto the phase grid.
   function automatic int unsigned clamp_loc(input int unsigned v, input int unsigned steps);
      return (v >= steps) ? steps - 1 : v;
   endfunction
endpackage

// File: rtl/pcg_phase.sv
module pcg_phase #(
   parameter int STEPS = 48,
   parameter int LOC_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   output logic [LOC_W-1:0] phase_o
);
   localparam logic [LOC_W-1:0] LAST = LOC_W'(STEPS - 1);

   initial begin
      assert (STEPS >= 2 && STEPS <= (1 << LOC_W))
         else $error("pcg_phase: STEPS does not fit LOC_W");
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run)       phase_o <= '0;
      else if (phase_o == LAST) phase_o <= '0;
      else                      phase_o <= phase_o + 1'b1;
   end

   a_r1_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o <= LAST);
   a_r1_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (run && phase_o == LAST) |=> phase_o == '0);
endmodule

// File: rtl/pcg_edge_win.sv
module pcg_edge_win #(
   parameter int STEPS = 48,
   parameter int LOC_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             hold,
   input  logic [LOC_W-1:0] phase,
   input  logic [LOC_W-1:0] rise_i,
   input  logic [LOC_W-1:0] fall_i,
   input  logic             pol_i,
   output logic             out_o,
   output logic             outn_o
);
   logic [LOC_W-1:0] rise_c, fall_c;
   logic             in_win, nxt;

   assign rise_c = LOC_W'(pcg_pkg::clamp_loc(32'(rise_i), STEPS));
   assign fall_c = LOC_W'(pcg_pkg::clamp_loc(32'(fall_i), STEPS));

   always_comb begin
      if (rise_c < fall_c)      in_win = (phase >= rise_c) && (phase < fall_c);
      else if (rise_c > fall_c) in_win = (phase >= rise_c) || (phase < fall_c);
      else                      in_win = 1'b0;
      nxt = (run && !hold && in_win) ^ pol_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_o  <= pol_i;
         outn_o <= !pol_i;
      end else begin
         out_o  <= nxt;
         outn_o <= !nxt;
      end
   end

   a_r3_equal_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_c == fall_c) |=> out_o == $past(pol_i));
   a_r9_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
      (!run || hold) |=> out_o == $past(pol_i));
endmodule

// File: rtl/pcg_strobe.sv
module pcg_strobe #(
   parameter int STEPS = 48,
   parameter int LOC_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [LOC_W-1:0] phase,
   input  logic [LOC_W-1:0] loc_i,
   output logic             pulse_o
);
   logic [LOC_W-1:0] loc_c;
   assign loc_c = LOC_W'(pcg_pkg::clamp_loc(32'(loc_i), STEPS));

   always_ff @(posedge clk) begin
      if (!rst_n) pulse_o <= 1'b0;
      else        pulse_o <= run && (phase == loc_c);
   end

   a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> !pulse_o);
endmodule

// File: rtl/pcg_edge_gen.sv
module pcg_edge_gen #(
   parameter int STEPS   = 48,
   parameter int LOC_W   = 6,
   parameter int H_PAIRS = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               core_rst_n,
   input  logic               h_pol,
   input  logic [LOC_W-1:0]   h_rise,
   input  logic [LOC_W-1:0]   h_fall,
   input  logic               rg_pol,
   input  logic [LOC_W-1:0]   rg_rise,
   input  logic [LOC_W-1:0]   rg_fall,
   input  logic [LOC_W-1:0]   shp_loc,
   input  logic [LOC_W-1:0]   shd_loc,
   input  logic               hblk_i,
   input  logic               hblk_retime,
   output logic [H_PAIRS-1:0] h_main_o,
   output logic [H_PAIRS-1:0] h_comp_o,
   output logic               rg_o,
   output logic               shp_o,
   output logic               shd_o
);
   initial begin
      assert (H_PAIRS >= 1) else $error("pcg_edge_gen: H_PAIRS must be >= 1");
   end

   logic [LOC_W-1:0] phase;
   logic             blank_q, blank_eff, rg_n_unused;

   pcg_phase #(.STEPS(STEPS), .LOC_W(LOC_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .run(core_rst_n), .phase_o(phase));

   always_ff @(posedge clk) begin
      if (!rst_n) blank_q <= 1'b0;
      else        blank_q <= hblk_i;
   end
   assign blank_eff = hblk_retime ? blank_q : hblk_i;

   for (genvar i = 0; i < H_PAIRS; i++) begin : g_hpair
      pcg_edge_win #(.STEPS(STEPS), .LOC_W(LOC_W)) u_h (
         .clk(clk), .rst_n(rst_n), .run(core_rst_n), .hold(blank_eff),
         .phase(phase), .rise_i(h_rise), .fall_i(h_fall), .pol_i(h_pol),
         .out_o(h_main_o[i]), .outn_o(h_comp_o[i]));
   end

   pcg_edge_win #(.STEPS(STEPS), .LOC_W(LOC_W)) u_rg (
      .clk(clk), .rst_n(rst_n), .run(core_rst_n), .hold(1'b0),
      .phase(phase), .rise_i(rg_rise), .fall_i(rg_fall), .pol_i(rg_pol),
      .out_o(rg_o), .outn_o(rg_n_unused));

   pcg_strobe #(.STEPS(STEPS), .LOC_W(LOC_W)) u_shp (
      .clk(clk), .rst_n(rst_n), .run(core_rst_n), .phase(phase),
      .loc_i(shp_loc), .pulse_o(shp_o));

   pcg_strobe #(.STEPS(STEPS), .LOC_W(LOC_W)) u_shd (
      .clk(clk), .rst_n(rst_n), .run(core_rst_n), .phase(phase),
      .loc_i(shd_loc), .pulse_o(shd_o));

   a_r9_blank_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (core_rst_n && blank_eff) |=> h_main_o[0] == $past(h_pol));
   a_r11_core_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !core_rst_n |=> (!shp_o && !shd_o && rg_o == $past(rg_pol)));
   a_r10_retime_delay: assert property (@(posedge clk) disable iff (!rst_n)
      (core_rst_n && hblk_retime && $past(hblk_retime) && $past(hblk_i))
      |=> h_main_o[H_PAIRS-1] == $past(h_pol));
endmodule

// File: tb/sim_pcg_edge_gen.sv
module sim_pcg_edge_gen;
   localparam int S = 48;
   localparam int P = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0, core_rst_n = 1'b0;
   logic h_pol = 1'b0, rg_pol = 1'b0, hblk_i = 1'b0, hblk_retime = 1'b0;
   logic [5:0] h_rise = 6'd0, h_fall = 6'd0, rg_rise = 6'd0, rg_fall = 6'd0;
   logic [5:0] shp_loc = 6'd0, shd_loc = 6'd0;
   logic [P-1:0] h_main_o, h_comp_o;
   logic rg_o, shp_o, shd_o;

   int checks = 0, fails = 0, cycles = 0;
   string cur_tag = "R12";
   bit all_tag = 1'b1;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pcg_edge_gen u0 (.*);

   // Reference model
   int ph = 0;
   bit bq = 1'b0;
   bit e_h = 1'b0, e_rg = 1'b0, e_sp = 1'b0, e_sd = 1'b0;

   function automatic int cl(input int v);
      return (v >= S) ? S - 1 : v;
   endfunction
   function automatic bit inside_win(input int p, input int r, input int f);
      int rc, fc;
      rc = cl(r); fc = cl(f);
      return ((p - rc + S) % S) < ((fc - rc + S) % S);
   endfunction

   always @(posedge clk) begin
      bit eff;
      eff = hblk_retime ? bq : hblk_i;
      if (!rst_n || !core_rst_n) begin
         e_h = h_pol; e_rg = rg_pol; e_sp = 1'b0; e_sd = 1'b0; ph = 0;
      end else begin
         e_h  = (inside_win(ph, int'(h_rise), int'(h_fall)) && !eff) ^ h_pol;
         e_rg = inside_win(ph, int'(rg_rise), int'(rg_fall)) ^ rg_pol;
         e_sp = (ph == cl(int'(shp_loc)));
         e_sd = (ph == cl(int'(shd_loc)));
         ph = (ph + 1) % S;
      end
      bq = rst_n ? hblk_i : 1'b0;
      cycles++;
   end

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cycles, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         for (int i = 0; i < P; i++) begin
            chk(cur_tag, h_main_o[i], e_h);
            chk(all_tag ? cur_tag : "R6", h_comp_o[i], !e_h);
         end
         chk(all_tag ? cur_tag : "R7", rg_o, e_rg);
         chk(all_tag ? cur_tag : "R8", shp_o, e_sp);
         chk(all_tag ? cur_tag : "R8", shd_o, e_sd);
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      // R12: reset state with polarities set
      h_pol = 1'b1; rg_pol = 1'b1;
      step(5);
      cur_tag = "R12"; h_pol = 1'b0; rg_pol = 1'b0; step(3);
      rst_n = 1'b1;
      cur_tag = "R11"; step(4);
      core_rst_n = 1'b1;
      all_tag = 1'b0;
      // R1 plain window
      cur_tag = "R1"; h_rise = 6'd10; h_fall = 6'd30;
      rg_rise = 6'd2; rg_fall = 6'd8; shp_loc = 6'd3; shd_loc = 6'd27;
      step(2 * S + 7);
      // R2 wrapped window
      cur_tag = "R2"; h_rise = 6'd40; h_fall = 6'd5; rg_rise = 6'd45; rg_fall = 6'd1;
      step(2 * S);
      // R3 equal locations
      cur_tag = "R3"; h_rise = 6'd20; h_fall = 6'd20; rg_rise = 6'd9; rg_fall = 6'd9;
      step(2 * S);
      // R4 clamping
      cur_tag = "R4"; h_rise = 6'd60; h_fall = 6'd20; shp_loc = 6'd63; shd_loc = 6'd50;
      rg_rise = 6'd12; rg_fall = 6'd55;
      step(2 * S);
      h_rise = 6'd47; h_fall = 6'd63; step(S);
      // R5 polarity
      cur_tag = "R5"; h_pol = 1'b1; h_rise = 6'd5; h_fall = 6'd25; step(2 * S);
      // R7 reset gate with own polarity
      cur_tag = "R7"; rg_pol = 1'b1; rg_rise = 6'd30; rg_fall = 6'd36; step(2 * S);
      // R8 strobe placements
      cur_tag = "R8"; h_pol = 1'b0; shp_loc = 6'd0; shd_loc = 6'd47; step(2 * S);
      // R9 blanking used directly
      cur_tag = "R9"; h_rise = 6'd0; h_fall = 6'd24;
      for (int k = 0; k < 6; k++) begin
         hblk_i = 1'b1; step(7 + k);
         hblk_i = 1'b0; step(11);
      end
      // R10 retimed blanking
      cur_tag = "R10"; hblk_retime = 1'b1;
      for (int k = 0; k < 6; k++) begin
         hblk_i = 1'b1; step(3 + k);
         hblk_i = 1'b0; step(13);
      end
      hblk_i = 1'b1; step(1); hblk_i = 1'b0; step(S);
      hblk_retime = 1'b0;
      // R11 core reset mid-period
      cur_tag = "R11"; all_tag = 1'b1; h_pol = 1'b1;
      step(17); core_rst_n = 1'b0; step(9); core_rst_n = 1'b1; step(2 * S);
      core_rst_n = 1'b0; step(1); core_rst_n = 1'b1; step(S);
      // R6 complement under mixed settings
      cur_tag = "R6"; all_tag = 1'b0; h_pol = 1'b0; h_rise = 6'd33; h_fall = 6'd2;
      step(2 * S);
      finish_run();
   end

   initial begin
      #3000000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule